// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the configuration store of an interrupt distributor. It holds, for every interrupt source, an enable bit, a trigger type, a CPU target mask and an 8-bit priority. It also captures the source input lines as level or rising-edge pending state. Software reaches it through a flat 32-bit word-addressed read/write port. Every access carries the number of the CPU making it, because sources 0 to 31 are private: each CPU has its own enable bits, input lines and pending state for them at the same addresses. Sources 32 and up are shared by all CPUs and are steered by their target masks.

Enables are never written directly. One address window sets enable bits and a second window clears them, so several agents can change different sources without a read-modify-write. A global forwarding bit gates every request output. The block presents, for each CPU, the vector of sources that are pending, enabled, targeted at that CPU and allowed by the global bit. Beside that vector it presents the priority byte of every source. A later arbitration stage consumes both.

Word addresses (10 bits) are grouped by bits [9:8]. Group 0 holds the control word at 0x000, the type word at 0x001, enable-set words at 0x040+k, enable-clear words at 0x060+k and pending words at 0x080+k. Here k is the source number divided by 32. Group 1 is priority at 0x100+w, group 2 is target at 0x200+w and group 3 is trigger type at 0x300+v. Here w is the source number divided by 4 and v is the source number divided by 16. Reads are combinational and writes take effect at the clock edge.

Top module: `dist_regbank`

## Requirements
- R1: After reset the control word, all enable, priority, target and trigger-type fields read 0, and `irqVec` is all zero.
- R2: At 0x040+k, a 1 in bit i sets the enable of source 32k+i. At 0x060+k, a 1 in bit i clears it. Zero bits change nothing, and both windows read back the current enable bits.
- R3: For k = 0, the enable and pending state of sources 0..31 is kept separately for each CPU and is selected by `busCpu`. Words with k >= 1 are shared by all CPUs.
- R4: In trigger word v, bit 2j+1 selects rising-edge (1) or level-high (0) for source 16v+j, and bit 2j reads 0. Word 0 (sources 0..15) ignores writes, reads 0 and is always level.
- R5: Byte b of priority word w (0x100+w) holds the priority of source 4w+b. It reads back as written and appears on `srcPrio[8s+7:8s]` for source s.
- R6: Byte b of target word w >= 8 is the CPU mask of source 4w+b, where bit c selects CPU c. Mask bits at or above NUM_CPU read 0. Target words 0..7 ignore writes and read 1<<busCpu in every byte.
- R7: Control word bit 0 (0x000) enables forwarding. While it is 0, `irqVec` is all zero.
- R8: The type word (0x001) reads NUM_SRC/32-1 in bits [4:0] (1 for 64 sources) and 0 elsewhere. Writes to it have no effect.
- R9: A level source is pending while its input, registered once, is high. `irqVec` follows the input one clock edge later.
- R10: An edge source becomes pending at the edge where its input is first seen high. It stays pending after the input falls, until a 1 is written to its bit of pending word 0x080+k. Writing 1 there has no effect on level sources. Pending words read the current pending state.
- R11: `irqVec[c*NUM_SRC+s]` is 1 when forwarding is on, source s is enabled and pending, and either s < 32 (seen from CPU c's copy of the banked state) or bit c of the target mask of s is set.
- R12: Addresses outside the groups above, words past the last source, and accesses with `busCpu` >= NUM_CPU read 0 and have no effect when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the addressed word |
| busAddr | input | 10 | Word address |
| busCpu | input | 3 | Number of the CPU making the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word (combinational) |
| privIn | input | NUM_CPU*32 | Private source lines, 32 per CPU, CPU c at bits [32c+31:32c] |
| shrIn | input | NUM_SRC-32 | Shared source lines, bit k is source 32+k |
| irqVec | output | NUM_CPU*NUM_SRC | Forwardable request per CPU and source |
| srcPrio | output | NUM_SRC*8 | Priority byte of every source |

## Verification
Some properties are checked on every cycle: an enable-clear write leaves none of the cleared private sources requesting on the next cycle, and turning forwarding off empties the request vector a cycle later. A priority write shows up on the priority output, the type word and the fixed trigger word always read their constant values, and an invalid CPU number always reads 0. The bench scenarios are needed to show banking between CPUs, target steering of shared sources, and the difference between level and edge sources. That difference covers an edge pending that outlives its input and is cleared only by software, and a level source that ignores the pending-clear write. The scenarios also cover the one-edge latency from an input line to the request vector.

// File: rtl/dist_pkg.sv
`timescale 1ns/1ps
package dist_pkg;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 8;
  localparam int CPUID_W = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_TYPE, SEL_ENSET, SEL_ENCLR,
    SEL_PEND, SEL_PRIO, SEL_TGT, SEL_CFG
  } selE;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrEnSet;
    logic             wrEnClr;
    logic             wrPendClr;
    logic             wrPrio;
    logic             wrTgt;
    logic             wrCfg;
    selE              rdSel;
    logic [IDX_W-1:0] idx;
  } strobeT;
endpackage

// File: rtl/dist_decode.sv
`timescale 1ns/1ps
module dist_decode import dist_pkg::*; #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CPUID_W-1:0] busCpu,
  output strobeT             stb
);
  localparam int ENW = NUM_SRC / 32;
  localparam int PRW = NUM_SRC / 4;
  localparam int CFW = NUM_SRC / 16;

  selE              sel;
  logic [IDX_W-1:0] idx;
  logic             cpuOk;
  logic             wrGo;

  always_comb begin
    cpuOk = int'(busCpu) < NUM_CPU;
    sel   = SEL_NONE;
    idx   = busAddr[7:0];
    unique case (busAddr[9:8])
      2'd0: begin
        idx = {3'b000, busAddr[4:0]};
        case (busAddr[7:5])
          3'd0: begin
            if (busAddr[4:0] == 5'd0)      sel = SEL_CTRL;
            else if (busAddr[4:0] == 5'd1) sel = SEL_TYPE;
          end
          3'd2: if (int'(busAddr[4:0]) < ENW) sel = SEL_ENSET;
          3'd3: if (int'(busAddr[4:0]) < ENW) sel = SEL_ENCLR;
          3'd4: if (int'(busAddr[4:0]) < ENW) sel = SEL_PEND;
          default: sel = SEL_NONE;
        endcase
      end
      2'd1: if (int'(busAddr[7:0]) < PRW) sel = SEL_PRIO;
      2'd2: if (int'(busAddr[7:0]) < PRW) sel = SEL_TGT;
      2'd3: if (int'(busAddr[7:0]) < CFW) sel = SEL_CFG;
    endcase
    if (!cpuOk) sel = SEL_NONE;

    wrGo          = busWr && (sel != SEL_NONE);
    stb.rdSel     = sel;
    stb.idx       = idx;
    stb.wrCtrl    = wrGo && (sel == SEL_CTRL);
    stb.wrEnSet   = wrGo && (sel == SEL_ENSET);
    stb.wrEnClr   = wrGo && (sel == SEL_ENCLR);
    stb.wrPendClr = wrGo && (sel == SEL_PEND);
    stb.wrPrio    = wrGo && (sel == SEL_PRIO);
    stb.wrTgt     = wrGo && (sel == SEL_TGT);
    stb.wrCfg     = wrGo && (sel == SEL_CFG);
  end
endmodule

// File: rtl/dist_store.sv
`timescale 1ns/1ps
module dist_store import dist_pkg::*; #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int NSHR   = NUM_SRC - 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     stb,
  input  logic [CPU_W-1:0]           cpuSel,
  input  logic [31:0]                wdata,
  input  logic [NUM_CPU*32-1:0]      privIn,
  input  logic [NSHR-1:0]            shrIn,
  output logic [31:0]                rdata,
  output logic [NUM_CPU*NUM_SRC-1:0] irqVec,
  output logic [NUM_SRC*8-1:0]       srcPrio
);
  localparam int ENW = NUM_SRC / 32;
  localparam int PRW = NUM_SRC / 4;
  localparam int CFW = NUM_SRC / 16;

  logic                             ctrlEnQ;
  logic [NUM_CPU-1:0][31:0]         enPrivQ, privInQ, privPendQ, privPendEff, privClr;
  logic [NSHR-1:0]                  enShrQ, shrInQ, shrPendQ, shrPendEff, shrClr;
  logic [NUM_SRC*8-1:0]             prioQ;
  logic [NSHR-1:0][NUM_CPU-1:0]     tgtQ;
  logic [NUM_SRC-1:16]              cfgEdgeQ;
  logic [NUM_SRC-1:0]               edgeAll;

  assign edgeAll = {cfgEdgeQ, 16'b0};
  assign srcPrio = prioQ;

  // Effective pending: edge sources use the latch, level sources the registered line
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      privPendEff[c] = (edgeAll[31:0] & privPendQ[c]) | (~edgeAll[31:0] & privInQ[c]);
    shrPendEff = (edgeAll[NUM_SRC-1:32] & shrPendQ) | (~edgeAll[NUM_SRC-1:32] & shrInQ);
  end

  // Pending-clear masks from the write window
  always_comb begin
    privClr = '0;
    shrClr  = '0;
    if (stb.wrPendClr) begin
      if (stb.idx == '0) privClr[cpuSel] = wdata;
      for (int w = 1; w < ENW; w++)
        if (stb.idx == IDX_W'(w)) shrClr[(w-1)*32 +: 32] = wdata;
    end
  end

  // Line capture and edge latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privInQ   <= '0;
      privPendQ <= '0;
      shrInQ    <= '0;
      shrPendQ  <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        privInQ[c]   <= privIn[c*32 +: 32];
        privPendQ[c] <= edgeAll[31:0] &
                        ((privPendQ[c] & ~privClr[c]) | (privIn[c*32 +: 32] & ~privInQ[c]));
      end
      shrInQ   <= shrIn;
      shrPendQ <= edgeAll[NUM_SRC-1:32] & ((shrPendQ & ~shrClr) | (shrIn & ~shrInQ));
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEnQ  <= 1'b0;
      enPrivQ  <= '0;
      enShrQ   <= '0;
      prioQ    <= '0;
      tgtQ     <= '0;
      cfgEdgeQ <= '0;
    end else begin
      if (stb.wrCtrl) ctrlEnQ <= wdata[0];
      if (stb.wrEnSet || stb.wrEnClr) begin
        if (stb.idx == '0)
          enPrivQ[cpuSel] <= stb.wrEnSet ? (enPrivQ[cpuSel] | wdata) : (enPrivQ[cpuSel] & ~wdata);
        for (int w = 1; w < ENW; w++)
          if (stb.idx == IDX_W'(w))
            enShrQ[(w-1)*32 +: 32] <= stb.wrEnSet ? (enShrQ[(w-1)*32 +: 32] | wdata)
                                                  : (enShrQ[(w-1)*32 +: 32] & ~wdata);
      end
      for (int w = 0; w < PRW; w++)
        if (stb.wrPrio && stb.idx == IDX_W'(w)) prioQ[w*32 +: 32] <= wdata;
      for (int w = 8; w < PRW; w++)
        if (stb.wrTgt && stb.idx == IDX_W'(w))
          for (int b = 0; b < 4; b++) tgtQ[(w-8)*4+b] <= wdata[8*b +: NUM_CPU];
      for (int w = 1; w < CFW; w++)
        if (stb.wrCfg && stb.idx == IDX_W'(w))
          for (int j = 0; j < 16; j++) cfgEdgeQ[16*w+j] <= wdata[2*j+1];
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      SEL_CTRL: rdata[0] = ctrlEnQ;
      SEL_TYPE: rdata[4:0] = 5'(ENW - 1);
      SEL_ENSET, SEL_ENCLR: begin
        if (stb.idx == '0) rdata = enPrivQ[cpuSel];
        for (int w = 1; w < ENW; w++)
          if (stb.idx == IDX_W'(w)) rdata = enShrQ[(w-1)*32 +: 32];
      end
      SEL_PEND: begin
        if (stb.idx == '0) rdata = privPendEff[cpuSel];
        for (int w = 1; w < ENW; w++)
          if (stb.idx == IDX_W'(w)) rdata = shrPendEff[(w-1)*32 +: 32];
      end
      SEL_PRIO: begin
        for (int w = 0; w < PRW; w++)
          if (stb.idx == IDX_W'(w)) rdata = prioQ[w*32 +: 32];
      end
      SEL_TGT: begin
        if (int'(stb.idx) < 8)
          for (int b = 0; b < 4; b++) rdata[8*b +: 8] = 8'(1) << cpuSel;
        for (int w = 8; w < PRW; w++)
          if (stb.idx == IDX_W'(w))
            for (int b = 0; b < 4; b++) rdata[8*b +: 8] = 8'(tgtQ[(w-8)*4+b]);
      end
      SEL_CFG: begin
        for (int w = 0; w < CFW; w++)
          if (stb.idx == IDX_W'(w))
            for (int j = 0; j < 16; j++) rdata[2*j+1] = edgeAll[16*w+j];
      end
      default: rdata = '0;
    endcase
  end

  // Request vector per CPU
  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    for (genvar i = 0; i < 32; i++) begin : gPriv
      assign irqVec[c*NUM_SRC+i] = ctrlEnQ & enPrivQ[c][i] & privPendEff[c][i];
    end
    for (genvar k = 0; k < NSHR; k++) begin : gShr
      assign irqVec[c*NUM_SRC+32+k] = ctrlEnQ & enShrQ[k] & shrPendEff[k] & tgtQ[k][c];
    end
  end
endmodule

// File: rtl/dist_regbank.sv
`timescale 1ns/1ps
module dist_regbank import dist_pkg::*; #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWr,
  input  logic [9:0]                 busAddr,
  input  logic [2:0]                 busCpu,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic [NUM_CPU*32-1:0]      privIn,
  input  logic [NUM_SRC-33:0]        shrIn,
  output logic [NUM_CPU*NUM_SRC-1:0] irqVec,
  output logic [NUM_SRC*8-1:0]       srcPrio
);
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  strobeT stb;

  dist_decode #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) uDecode (
    .busWr   (busWr),
    .busAddr (busAddr),
    .busCpu  (busCpu),
    .stb     (stb)
  );

  dist_store #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) uStore (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cpuSel  (busCpu[CPU_W-1:0]),
    .wdata   (busWdata),
    .privIn  (privIn),
    .shrIn   (shrIn),
    .rdata   (busRdata),
    .irqVec  (irqVec),
    .srcPrio (srcPrio)
  );
endmodule

// File: rtl/dist_regbank_chk.sv
`timescale 1ns/1ps
module dist_regbank_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busWr,
  input logic [9:0]                 busAddr,
  input logic [2:0]                 busCpu,
  input logic [31:0]                busWdata,
  input logic [31:0]                busRdata,
  input logic [NUM_CPU*NUM_SRC-1:0] irqVec,
  input logic [NUM_SRC*8-1:0]       srcPrio
);
  logic        cpuOk;
  logic        prevClrQ, prevOffQ, prevPrioQ;
  logic [2:0]  prevCpuQ;
  logic [31:0] prevWdQ;
  logic [7:0]  prevIdxQ;
  logic [31:0] privSlice, prioWord;

  assign cpuOk = int'(busCpu) < NUM_CPU;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClrQ  <= 1'b0;
      prevOffQ  <= 1'b0;
      prevPrioQ <= 1'b0;
      prevCpuQ  <= '0;
      prevWdQ   <= '0;
      prevIdxQ  <= '0;
    end else begin
      prevClrQ  <= busWr && cpuOk && (busAddr == 10'h060);
      prevOffQ  <= busWr && cpuOk && (busAddr == 10'h000) && !busWdata[0];
      prevPrioQ <= busWr && cpuOk && (busAddr[9:8] == 2'd1) && (int'(busAddr[7:0]) < NUM_SRC/4);
      prevCpuQ  <= busCpu;
      prevWdQ   <= busWdata;
      prevIdxQ  <= busAddr[7:0];
    end
  end

  always_comb begin
    privSlice = '0;
    prioWord  = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (prevCpuQ == 3'(c)) privSlice = irqVec[c*NUM_SRC +: 32];
    for (int w = 0; w < NUM_SRC/4; w++)
      if (prevIdxQ == 8'(w)) prioWord = srcPrio[w*32 +: 32];
  end

  p_enclr_r2: assert property (@(posedge clk) disable iff (!rstN)
    prevClrQ |-> ((privSlice & prevWdQ) == 32'h0))
    else $error("enable-clear left a request active");

  p_fwd_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    prevOffQ |-> (irqVec == '0))
    else $error("requests present with forwarding off");

  p_prio_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    prevPrioQ |-> (prioWord == prevWdQ))
    else $error("priority output does not match write");

  p_type_ro_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOk && busAddr == 10'h001) |-> (busRdata == 32'(NUM_SRC/32 - 1)))
    else $error("type word wrong");

  p_cfg_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOk && busAddr == 10'h300) |-> (busRdata == 32'h0))
    else $error("fixed trigger word not zero");

  p_bad_cpu_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuOk) |-> (busRdata == 32'h0))
    else $error("invalid CPU read nonzero");
endmodule

bind dist_regbank dist_regbank_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busCpu   (busCpu),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqVec   (irqVec),
  .srcPrio  (srcPrio)
);

// File: tb/tb_dist_regbank.sv
`timescale 1ns/1ps
module tb_dist_regbank;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 2;
  localparam int NV = 35;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       busWr = 1'b0;
  logic [9:0]                 busAddr = '0;
  logic [2:0]                 busCpu = '0;
  logic [31:0]                busWdata = '0;
  logic [31:0]                busRdata;
  logic [NUM_CPU*32-1:0]      privIn = '0;
  logic [NUM_SRC-33:0]        shrIn = '0;
  logic [NUM_CPU*NUM_SRC-1:0] irqVec;
  logic [NUM_SRC*8-1:0]       srcPrio;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  dist_regbank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busCpu(busCpu),
    .busWdata(busWdata), .busRdata(busRdata), .privIn(privIn), .shrIn(shrIn),
    .irqVec(irqVec), .srcPrio(srcPrio)
  );

  // {isWr, addr[9:0], cpu[2:0], data[31:0], req[7:0]}
  localparam logic [53:0] TBL [0:NV-1] = '{
    {1'b0, 10'h000, 3'd0, 32'h00000000, 8'd1},  // R1 control
    {1'b0, 10'h040, 3'd0, 32'h00000000, 8'd1},  // R1 enables
    {1'b0, 10'h100, 3'd0, 32'h00000000, 8'd1},  // R1 priority
    {1'b0, 10'h001, 3'd0, 32'h00000001, 8'd8},  // R8 type
    {1'b1, 10'h001, 3'd0, 32'hFFFFFFFF, 8'd8},
    {1'b0, 10'h001, 3'd0, 32'h00000001, 8'd8},  // R8 read-only
    {1'b1, 10'h040, 3'd0, 32'h000000F0, 8'd2},
    {1'b1, 10'h040, 3'd0, 32'h00000003, 8'd2},
    {1'b0, 10'h040, 3'd0, 32'h000000F3, 8'd2},  // R2 set, zeros keep
    {1'b1, 10'h060, 3'd0, 32'h00000011, 8'd2},
    {1'b0, 10'h060, 3'd0, 32'h000000E2, 8'd2},  // R2 clear, read via clear window
    {1'b0, 10'h040, 3'd1, 32'h00000000, 8'd3},  // R3 other CPU copy untouched
    {1'b1, 10'h041, 3'd1, 32'h80000001, 8'd3},
    {1'b0, 10'h041, 3'd0, 32'h80000001, 8'd3},  // R3 shared word seen by all
    {1'b1, 10'h103, 3'd0, 32'hA1B2C3D4, 8'd5},
    {1'b0, 10'h103, 3'd0, 32'hA1B2C3D4, 8'd5},  // R5
    {1'b0, 10'h102, 3'd0, 32'h00000000, 8'd5},  // R5 neighbour word
    {1'b1, 10'h208, 3'd0, 32'hFF02FF03, 8'd6},
    {1'b0, 10'h208, 3'd0, 32'h03020303, 8'd6},  // R6 masks trimmed
    {1'b0, 10'h200, 3'd1, 32'h02020202, 8'd6},  // R6 private target
    {1'b1, 10'h200, 3'd0, 32'hFFFFFFFF, 8'd6},
    {1'b0, 10'h200, 3'd0, 32'h01010101, 8'd6},  // R6 private ignores write
    {1'b1, 10'h301, 3'd0, 32'hFFFFFFFF, 8'd4},
    {1'b0, 10'h301, 3'd0, 32'hAAAAAAAA, 8'd4},  // R4 upper bits only
    {1'b1, 10'h300, 3'd0, 32'hFFFFFFFF, 8'd4},
    {1'b0, 10'h300, 3'd0, 32'h00000000, 8'd4},  // R4 fixed word
    {1'b1, 10'h302, 3'd0, 32'h00000008, 8'd4},
    {1'b0, 10'h302, 3'd0, 32'h00000008, 8'd4},  // R4 source 33 edge
    {1'b1, 10'h020, 3'd0, 32'hFFFFFFFF, 8'd12},
    {1'b0, 10'h020, 3'd0, 32'h00000000, 8'd12}, // R12 hole
    {1'b1, 10'h040, 3'd2, 32'hFFFF0000, 8'd12},
    {1'b0, 10'h040, 3'd0, 32'h000000E2, 8'd12}, // R12 invalid CPU write ignored
    {1'b0, 10'h040, 3'd3, 32'h00000000, 8'd12}, // R12 invalid CPU read
    {1'b0, 10'h110, 3'd0, 32'h00000000, 8'd12}, // R12 past last priority word
    {1'b0, 10'h042, 3'd0, 32'h00000000, 8'd12}  // R12 past last enable word
  };

  task automatic check(input bit ok, input int req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [9:0] a, input logic [2:0] c, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busCpu = c; busWdata = d;
    step();
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdChk(input logic [9:0] a, input logic [2:0] c, input logic [31:0] e, input int req);
    busWr = 1'b0; busAddr = a; busCpu = c;
    #1;
    check(busRdata == e, req, 128'(busRdata), 128'(e));
  endtask

  task automatic bitChk(input int idx, input bit e, input int req);
    check(irqVec[idx] == e, req, 128'(irqVec[idx]), 128'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    check(irqVec == '0, 1, 128'(irqVec), 128'h0);  // R1

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][53]) wr(TBL[i][52:43], TBL[i][42:40], TBL[i][39:8]);
      else rdChk(TBL[i][52:43], TBL[i][42:40], TBL[i][39:8], int'(TBL[i][7:0]));
    end

    // R7: level source 1 on CPU 0 enabled, forwarding still off
    privIn[1] = 1'b1;
    step();
    check(irqVec == '0, 7, 128'(irqVec), 128'h0);
    // R11: forwarding on, only CPU 0 source 1 requests
    wr(10'h000, 3'd0, 32'h1);
    check(irqVec == 128'h2, 11, 128'(irqVec), 128'h2);
    // R9: input drop visible only after one edge
    privIn[1] = 1'b0;
    #1 bitChk(1, 1'b1, 9);
    step();
    bitChk(1, 1'b0, 9);

    // R3: CPU 1 private line, CPU 1 enable off
    privIn[32+1] = 1'b1;
    step();
    bitChk(NUM_SRC+1, 1'b0, 3);
    rdChk(10'h080, 3'd1, 32'h00000002, 3);
    rdChk(10'h080, 3'd0, 32'h00000000, 3);
    wr(10'h040, 3'd1, 32'h2);
    bitChk(NUM_SRC+1, 1'b1, 3);
    bitChk(1, 1'b0, 3);
    privIn[32+1] = 1'b0;
    step();

    // R10: edge source 17 on CPU 0
    wr(10'h040, 3'd0, 32'h00020000);
    privIn[17] = 1'b1;
    step();
    privIn[17] = 1'b0;
    step();
    step();
    bitChk(17, 1'b1, 10);
    rdChk(10'h080, 3'd0, 32'h00020000, 10);
    wr(10'h080, 3'd0, 32'h00020000);
    bitChk(17, 1'b0, 10);
    rdChk(10'h080, 3'd0, 32'h00000000, 10);
    // R10: pending clear has no effect on level source 1
    privIn[1] = 1'b1;
    step();
    wr(10'h080, 3'd0, 32'h2);
    bitChk(1, 1'b1, 10);
    privIn[1] = 1'b0;
    step();

    // R11: shared level source 32, target mask 3
    shrIn[0] = 1'b1;
    step();
    bitChk(32, 1'b1, 11);
    bitChk(NUM_SRC+32, 1'b1, 11);
    // R6: retarget source 32 to CPU 1 only
    wr(10'h208, 3'd0, 32'h00000002);
    bitChk(32, 1'b0, 6);
    bitChk(NUM_SRC+32, 1'b1, 6);
    // R6: source 63 enabled but untargeted
    shrIn[31] = 1'b1;
    step();
    bitChk(63, 1'b0, 6);
    bitChk(NUM_SRC+63, 1'b0, 6);
    wr(10'h20F, 3'd0, 32'h01000000);
    bitChk(63, 1'b1, 6);
    bitChk(NUM_SRC+63, 1'b0, 6);

    // R5: priority output
    check(srcPrio[127:96] == 32'hA1B2C3D4, 5, 128'(srcPrio[127:96]), 128'hA1B2C3D4);

    // R7: forwarding off empties every request
    wr(10'h000, 3'd0, 32'h0);
    check(irqVec == '0, 7, 128'(irqVec), 128'h0);
    rdChk(10'h000, 3'd0, 32'h0, 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule